// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block maps the per-pin interrupt requests of three GPIO banks onto a fixed set of 41 interrupt-controller input lines. Bank A has 14 request lines, bank B has 24 and bank C has 32. The controller has fewer lines than there are pins, so banks A and B share the 32 lowest lines with bank C. A 32-bit routing register has one bit per shared line. Each bit chooses which source drives that line. The six highest pins of bank B always have their own lines.

Any request that has no line of its own is not lost. One summary line per bank carries the OR of that bank's requests that currently have no direct line. After reset every routing bit is zero, so banks A and B own the shared lines and all of bank C goes through its summary line. Software writes the routing register through a one-register write port and can read it back at any time. The outputs are combinational from the request inputs and the registered routing bits.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the routing register reads back as all zeros.
- R2: A cycle with `route_we` high loads `route_wdata` into the routing register, and `route_rdata` shows it after that clock edge. Without a write the register holds its value.
- R3: For k in 0..13, `irq_line[k]` equals bank C pin k when routing bit k is 1, and bank A pin k when it is 0.
- R4: For k in 14..31, `irq_line[k]` equals bank C pin k when routing bit k is 1, and bank B pin k-14 when it is 0.
- R5: `irq_line[37:32]` always equals bank B pins 23..18 in that order (line 32 is pin 18), whatever the routing bits are.
- R6: `irq_line[38]` is the OR of every bank A pin k whose routing bit k is 1.
- R7: `irq_line[39]` is the OR of every bank B pin j (j in 0..17) whose routing bit j+14 is 1. Pins 18..23 never drive it.
- R8: `irq_line[40]` is the OR of every bank C pin k whose routing bit k is 0.
- R9: A change on the request inputs appears on `irq_line` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_we | input | 1 | Write strobe for the routing register |
| route_wdata | input | 32 | New routing register value |
| route_rdata | output | 32 | Current routing register value |
| bank_a_req | input | 14 | Bank A pin interrupt requests |
| bank_b_req | input | 24 | Bank B pin interrupt requests |
| bank_c_req | input | 32 | Bank C pin interrupt requests |
| irq_line | output | 41 | Lines to the interrupt controller |

## Verification
A routing write becomes visible one clock edge after the strobe cycle. The bench drives each write on a falling edge, lets one rising edge pass and only then reads back or checks any routed line. Request changes need no clock edge, so the bench applies each request pattern and samples `irq_line` one time unit later, with the routing register held still. Each routing pattern (zero, all ones, every single bit, pseudo-random words) is swept against single-pin and pseudo-random request patterns, and every output field is compared with a value computed from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int AGG_LINES = 3;

    typedef enum logic [1:0] {
        AGG_BANK_A = 2'd0,
        AGG_BANK_B = 2'd1,
        AGG_BANK_C = 2'd2
    } agg_idx_e;
endpackage

// File: rtl/gpio_route_reg.sv
module gpio_route_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] route_q
);
    typedef struct packed {
        logic [WIDTH-1:0] route;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.route = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign route_q = state_q.route;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (route_q == '0));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst)) |-> (route_q == $past(wdata)));

    p_hold_value_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(we) && !$past(rst)) |-> $stable(route_q));
endmodule

// File: rtl/gpio_slot_mux.sv
module gpio_slot_mux #(
    parameter int A_PINS = 14,
    parameter int B_PINS = 24,
    parameter int C_PINS = 32
) (
    input  logic [A_PINS-1:0]        a_req,
    input  logic [B_PINS-1:0]        b_req,
    input  logic [C_PINS-1:0]        c_req,
    input  logic [C_PINS-1:0]        route,
    output logic [A_PINS+B_PINS-1:0] direct
);
    localparam int N_DIRECT = A_PINS + B_PINS;

    for (genvar k = 0; k < C_PINS; k++) begin : g_shared
        logic home_src;
        if (k < A_PINS) begin : g_from_a
            assign home_src = a_req[k];
        end else begin : g_from_b
            assign home_src = b_req[k-A_PINS];
        end
        assign direct[k] = route[k] ? c_req[k] : home_src;
    end

    for (genvar k = C_PINS; k < N_DIRECT; k++) begin : g_fixed
        assign direct[k] = b_req[k-A_PINS];
    end
endmodule

// File: rtl/gpio_orphan_or.sv
module gpio_orphan_or #(
    parameter int A_PINS   = 14,
    parameter int B_SHARED = 18,
    parameter int C_PINS   = 32
) (
    input  logic [A_PINS-1:0]   a_req,
    input  logic [B_SHARED-1:0] b_shared_req,
    input  logic [C_PINS-1:0]   c_req,
    input  logic [C_PINS-1:0]   route,
    output logic [2:0]          orphan
);
    logic [A_PINS-1:0]   a_lost;
    logic [B_SHARED-1:0] b_lost;
    logic [C_PINS-1:0]   c_lost;

    always_comb begin
        a_lost    = a_req & route[A_PINS-1:0];
        b_lost    = b_shared_req & route[C_PINS-1:A_PINS];
        c_lost    = c_req & ~route;
        orphan[0] = |a_lost;
        orphan[1] = |b_lost;
        orphan[2] = |c_lost;
    end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int A_PINS = 14,
    parameter int B_PINS = 24,
    parameter int C_PINS = 32
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                route_we,
    input  logic [C_PINS-1:0]                   route_wdata,
    output logic [C_PINS-1:0]                   route_rdata,
    input  logic [A_PINS-1:0]                   bank_a_req,
    input  logic [B_PINS-1:0]                   bank_b_req,
    input  logic [C_PINS-1:0]                   bank_c_req,
    output logic [A_PINS+B_PINS+AGG_LINES-1:0]  irq_line
);
    localparam int B_SHARED = C_PINS - A_PINS;
    localparam int N_DIRECT = A_PINS + B_PINS;
    localparam int LINE_A   = N_DIRECT + int'(AGG_BANK_A);
    localparam int LINE_B   = N_DIRECT + int'(AGG_BANK_B);
    localparam int LINE_C   = N_DIRECT + int'(AGG_BANK_C);

    logic [C_PINS-1:0]   route_q;
    logic [N_DIRECT-1:0] direct;
    logic [2:0]          orphan;

    gpio_route_reg #(.WIDTH(C_PINS)) u_route (
        .clk    (clk),
        .rst    (rst),
        .we     (route_we),
        .wdata  (route_wdata),
        .route_q(route_q)
    );

    gpio_slot_mux #(.A_PINS(A_PINS), .B_PINS(B_PINS), .C_PINS(C_PINS)) u_mux (
        .a_req (bank_a_req),
        .b_req (bank_b_req),
        .c_req (bank_c_req),
        .route (route_q),
        .direct(direct)
    );

    gpio_orphan_or #(.A_PINS(A_PINS), .B_SHARED(B_SHARED), .C_PINS(C_PINS)) u_orphan (
        .a_req       (bank_a_req),
        .b_shared_req(bank_b_req[B_SHARED-1:0]),
        .c_req       (bank_c_req),
        .route       (route_q),
        .orphan      (orphan)
    );

    assign route_rdata = route_q;
    assign irq_line    = {orphan, direct};

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ((bank_a_req == '0) && (bank_b_req == '0) && (bank_c_req == '0))
            |-> (irq_line == '0));

    p_a_visible_r6: assert property (@(posedge clk) disable iff (rst)
        (|bank_a_req) |-> ((|irq_line[A_PINS-1:0]) || irq_line[LINE_A]));

    p_b_visible_r7: assert property (@(posedge clk) disable iff (rst)
        (|bank_b_req) |-> ((|irq_line[N_DIRECT-1:A_PINS]) || irq_line[LINE_B]));

    p_c_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (|bank_c_req) |-> ((|irq_line[C_PINS-1:0]) || irq_line[LINE_C]));

    p_fixed_lines_r5: assert property (@(posedge clk) disable iff (rst)
        $stable(bank_b_req[B_PINS-1:B_SHARED]) |-> $stable(irq_line[N_DIRECT-1:C_PINS]));
endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        route_we = 1'b0;
    logic [31:0] route_wdata = '0;
    logic [31:0] route_rdata;
    logic [13:0] a_req = '0;
    logic [23:0] b_req = '0;
    logic [31:0] c_req = '0;
    logic [40:0] irq_line;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5679;

    gpio_irq_router uut (
        .clk        (clk),
        .rst        (rst),
        .route_we   (route_we),
        .route_wdata(route_wdata),
        .route_rdata(route_rdata),
        .bank_a_req (a_req),
        .bank_b_req (b_req),
        .bank_c_req (c_req),
        .irq_line   (irq_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [40:0] model(input logic [31:0] r, input logic [13:0] a,
                                          input logic [23:0] b, input logic [31:0] c);
        logic [40:0] v;
        v = '0;
        for (int k = 0; k < 14; k++) v[k] = r[k] ? c[k] : a[k];
        for (int k = 14; k < 32; k++) v[k] = r[k] ? c[k] : b[k-14];
        for (int k = 32; k < 38; k++) v[k] = b[k-14];
        for (int k = 0; k < 14; k++) if (r[k] && a[k]) v[38] = 1'b1;
        for (int j = 0; j < 18; j++) if (r[j+14] && b[j]) v[39] = 1'b1;
        for (int k = 0; k < 32; k++) if (!r[k] && c[k]) v[40] = 1'b1;
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic write_route(input logic [31:0] v);
        @(negedge clk);
        route_we    = 1'b1;
        route_wdata = v;
        @(negedge clk);
        route_we    = 1'b0;
    endtask

    task automatic apply_and_check(input logic [31:0] r);
        logic [40:0] e;
        #1;
        e = model(r, a_req, b_req, c_req);
        check("R3", 64'(irq_line[13:0]),  64'(e[13:0]));
        check("R4", 64'(irq_line[31:14]), 64'(e[31:14]));
        check("R5", 64'(irq_line[37:32]), 64'(e[37:32]));
        check("R6", 64'(irq_line[38]),    64'(e[38]));
        check("R7", 64'(irq_line[39]),    64'(e[39]));
        check("R8", 64'(irq_line[40]),    64'(e[40]));
    endtask

    task automatic sweep_requests(input logic [31:0] r);
        a_req = '0; b_req = '0; c_req = '0;
        apply_and_check(r);
        for (int i = 0; i < 14; i++) begin
            a_req = 14'(1) << i; b_req = '0; c_req = '0;
            apply_and_check(r);
        end
        for (int i = 0; i < 24; i++) begin
            a_req = '0; b_req = 24'(1) << i; c_req = '0;
            apply_and_check(r);
        end
        for (int i = 0; i < 32; i++) begin
            a_req = '0; b_req = '0; c_req = 32'(1) << i;
            apply_and_check(r);
        end
        for (int i = 0; i < 6; i++) begin
            seed = next_rand(seed); a_req = seed[13:0];
            seed = next_rand(seed); b_req = seed[23:0];
            seed = next_rand(seed); c_req = seed;
            apply_and_check(r);
        end
    endtask

    task automatic run_route(input logic [31:0] r);
        write_route(r);
        check("R2", 64'(route_rdata), 64'(r));
        sweep_requests(r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 64'(route_rdata), 64'(0));
        sweep_requests(32'h0);

        // R9: request change between edges shows up without a clock edge
        @(negedge clk);
        a_req = '0; b_req = '0; c_req = '0;
        #1;
        check("R9", 64'(irq_line), 64'(0));
        b_req = 24'h80_0000;
        #1;
        check("R9", 64'(irq_line), 64'(41'(1) << 37));

        run_route(32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) run_route(32'(1) << i);
        for (int i = 0; i < 24; i++) begin
            seed = next_rand(seed);
            run_route(seed);
        end

        // R2: idle cycles keep the register value
        write_route(32'hA5C3_0F96);
        repeat (4) @(negedge clk);
        check("R2", 64'(route_rdata), 64'(32'hA5C3_0F96));

        // R7: fixed bank B pins never reach the bank B summary line
        write_route(32'hFFFF_FFFF);
        a_req = '0; c_req = '0; b_req = 24'hFC_0000;
        #1;
        check("R7", 64'(irq_line[39]), 64'(0));
        check("R5", 64'(irq_line[37:32]), 64'(6'h3F));

        // R1: a second reset clears the register again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 64'(route_rdata), 64'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule